// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block is a wall-clock peripheral that sits on a simple synchronous register bus. A free-running 32-bit seconds count steps forward by one on every pulse of an externally generated once-per-second tick, and wraps from all ones back to zero. Software can force the count to any start value through a load register, and can program a match value. The cycle in which the count arrives at the match value (or a register write leaves the two equal) raises a sticky alarm flag, which a one-bit enable passes onto a level interrupt line.

The bus is a single-cycle interface: one cycle with select high performs a write (write enable high) or a read (write enable low), and read data appears on the registered read port in the following cycle. Byte address bits below bit 2 are ignored. Besides the eight working registers in the lowest 32 bytes, the highest 32 bytes of the 4 KiB window return eight fixed identification bytes, one per word. Any other address reads as zero and ignores writes.

Top module: `sec_alarm_rtc`

## Requirements
- R1: After an active-low synchronous reset, the count, match, load, interrupt enable and alarm flag are all zero, the interrupt output is low and the read data is zero.
- R2: Every cycle in which the tick input is high and no load write occurs, the count rises by exactly one; 0xFFFFFFFF steps to 0x00000000.
- R3: A write to offset 0x08 sets the count to the written data on the next cycle (taking priority over a tick in the same cycle), and reads of 0x08 return the last value written there.
- R4: Offset 0x04 holds the match value (read/write). When a tick moves the count onto the match value, the alarm flag is set from the same clock edge that updates the count; a match value below the count is therefore reached only after the count wraps.
- R5: A write to 0x04 or 0x08 that leaves the match value equal to the resulting count sets the alarm flag at once, on the edge that performs the write.
- R6: A write to 0x10 stores bit 0 of the data as the interrupt enable (read back at 0x10 as bit 0). The interrupt output equals alarm flag AND enable; 0x14 reads the alarm flag in bit 0 and 0x18 reads flag AND enable in bit 0.
- R7: Any write to 0x1C clears the alarm flag regardless of the data; if a match event happens in the same cycle, the flag is set instead.
- R8: Offset 0x0C always reads 0x00000001 and writes to it change nothing.
- R9: Reads of 0xFE0, 0xFE4, 0xFE8, 0xFEC, 0xFF0, 0xFF4, 0xFF8, 0xFFC return, in that address order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0 with the upper bits zero.
- R10: Reads of 0x1C and of any address outside the two windows return zero; writes to 0x00, 0x14, 0x18, the identification words and unmapped addresses change no register.
- R11: Read data is registered: it reflects register contents at the request cycle, appears one cycle later, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_sec | input | 1 | One-cycle pulse per elapsed second |
| bus_sel | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt: alarm flag AND enable |

## Verification
The checker assumes the tick input is a clean one-cycle pulse per second and that every bus request lasts exactly one cycle with a word-aligned address; the bench's tasks raise select or tick for a single cycle at a falling edge and drop it at the next, and only pass aligned offsets. The properties also take for granted that a load or match write and a tick may coincide, so the bench deliberately overlaps them and overlaps a clear with a match event to exercise the priority rules.

// File: rtl/sec_alarm_pkg.sv
package sec_alarm_pkg;

  // Word index of the working registers inside the low window.
  typedef enum logic [2:0] {
    RI_COUNT  = 3'd0,
    RI_MATCH  = 3'd1,
    RI_LOAD   = 3'd2,
    RI_CTRL   = 3'd3,
    RI_ENABLE = 3'd4,
    RI_RAW    = 3'd5,
    RI_MASKED = 3'd6,
    RI_CLEAR  = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic wr_match;
    logic wr_load;
    logic wr_enable;
    logic wr_clear;
    logic rd;
  } reg_strobe_t;

  // Identification byte for word index i of the top window.
  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0:    return 8'h31;
      3'd1:    return 8'h10;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/sec_alarm_counter.sv
module sec_alarm_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_sec,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] ld_val,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] cnt_nxt,
  output logic [DATA_W-1:0] load_q,
  output logic              cnt_moved
);

  // Modular successor; the carry out of the top bit is dropped.
  function automatic logic [DATA_W-1:0] wrap_inc(input logic [DATA_W-1:0] v);
    logic [DATA_W:0] wide;
    wide = {1'b0, v} + {{DATA_W{1'b0}}, 1'b1};
    return wide[DATA_W-1:0];
  endfunction

  always_comb begin
    if (ld_en)         cnt_nxt = ld_val;
    else if (tick_sec) cnt_nxt = wrap_inc(cnt_q);
    else               cnt_nxt = cnt_q;
  end

  assign cnt_moved = ld_en | tick_sec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (ld_en) load_q <= ld_val;
    end
  end

endmodule

// File: rtl/sec_alarm_match.sv
module sec_alarm_match #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match_wr,
  input  logic [DATA_W-1:0] match_wdata,
  input  logic [DATA_W-1:0] cnt_nxt,
  input  logic              cnt_moved,
  input  logic              enable_wr,
  input  logic              enable_bit,
  input  logic              clear_wr,
  output logic [DATA_W-1:0] match_q,
  output logic              flag_q,
  output logic              enable_q,
  output logic              match_evt,
  output logic              irq
);

  logic [DATA_W-1:0] match_nxt;

  // Distance from count to match, wrapping; zero means they meet.
  function automatic logic [DATA_W-1:0] gap(input logic [DATA_W-1:0] m,
                                           input logic [DATA_W-1:0] c);
    return m - c;
  endfunction

  assign match_nxt = match_wr ? match_wdata : match_q;
  // Only a change of count or match can create a fresh meeting.
  assign match_evt = (cnt_moved | match_wr) && (gap(match_nxt, cnt_nxt) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q  <= '0;
      flag_q   <= 1'b0;
      enable_q <= 1'b0;
    end else begin
      match_q <= match_nxt;
      if (enable_wr) enable_q <= enable_bit;
      if (match_evt)     flag_q <= 1'b1;
      else if (clear_wr) flag_q <= 1'b0;
    end
  end

  assign irq = flag_q & enable_q;

endmodule

// File: rtl/sec_alarm_regs.sv
module sec_alarm_regs
  import sec_alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] cnt_q,
  input  logic [DATA_W-1:0] match_q,
  input  logic [DATA_W-1:0] load_q,
  input  logic              enable_q,
  input  logic              flag_q,
  output reg_strobe_t       strb,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned WIN_LSB = 5;
  localparam int unsigned PAGE_W  = ADDR_W - WIN_LSB;

  logic [PAGE_W-1:0] page;
  logic              in_regs;
  logic              in_id;
  reg_idx_e          idx;
  logic [DATA_W-1:0] rd_mux;

  assign page    = bus_addr[ADDR_W-1:WIN_LSB];
  assign in_regs = (page == '0);
  assign in_id   = (page == '1);
  assign idx     = reg_idx_e'(bus_addr[WIN_LSB-1:2]);

  always_comb begin
    strb           = '0;
    strb.rd        = bus_sel & ~bus_we;
    if (bus_sel && bus_we && in_regs) begin
      strb.wr_match  = (idx == RI_MATCH);
      strb.wr_load   = (idx == RI_LOAD);
      strb.wr_enable = (idx == RI_ENABLE);
      strb.wr_clear  = (idx == RI_CLEAR);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_regs) begin
      case (idx)
        RI_COUNT:  rd_mux = cnt_q;
        RI_MATCH:  rd_mux = match_q;
        RI_LOAD:   rd_mux = load_q;
        RI_CTRL:   rd_mux = DATA_W'(1);
        RI_ENABLE: rd_mux = DATA_W'(enable_q);
        RI_RAW:    rd_mux = DATA_W'(flag_q);
        RI_MASKED: rd_mux = DATA_W'(flag_q & enable_q);
        default:   rd_mux = '0;
      endcase
    end else if (in_id) begin
      rd_mux = DATA_W'(id_byte(bus_addr[WIN_LSB-1:2]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (strb.rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/sec_alarm_rtc.sv
module sec_alarm_rtc
  import sec_alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_sec,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  reg_strobe_t       strb;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] cnt_nxt;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] match_q;
  logic              cnt_moved;
  logic              flag_q;
  logic              enable_q;
  logic              match_evt;

  sec_alarm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .cnt_q    (cnt_q),
    .match_q  (match_q),
    .load_q   (load_q),
    .enable_q (enable_q),
    .flag_q   (flag_q),
    .strb     (strb),
    .bus_rdata(bus_rdata)
  );

  sec_alarm_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_sec (tick_sec),
    .ld_en    (strb.wr_load),
    .ld_val   (bus_wdata),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt),
    .load_q   (load_q),
    .cnt_moved(cnt_moved)
  );

  sec_alarm_match #(.DATA_W(DATA_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_wr   (strb.wr_match),
    .match_wdata(bus_wdata),
    .cnt_nxt    (cnt_nxt),
    .cnt_moved  (cnt_moved),
    .enable_wr  (strb.wr_enable),
    .enable_bit (bus_wdata[0]),
    .clear_wr   (strb.wr_clear),
    .match_q    (match_q),
    .flag_q     (flag_q),
    .enable_q   (enable_q),
    .match_evt  (match_evt),
    .irq        (irq)
  );

endmodule

// File: rtl/sec_alarm_rtc_chk.sv
module sec_alarm_rtc_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_sec,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [DATA_W-1:0] cnt_q,
  input logic              flag_q,
  input logic              enable_q,
  input logic              match_evt
);

  logic wr_any, rd_any, ld_wr, clr_wr, en_wr, ctl_rd, hole_rd;
  assign wr_any  = bus_sel & bus_we;
  assign rd_any  = bus_sel & ~bus_we;
  assign ld_wr   = wr_any && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2));
  assign clr_wr  = wr_any && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(7));
  assign en_wr   = wr_any && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(4));
  assign ctl_rd  = rd_any && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3));
  assign hole_rd = rd_any && (bus_addr[ADDR_W-1:5] != '0) && (bus_addr[ADDR_W-1:5] != '1);

  // R2: a tick without a load moves the count by one, modulo 2^DATA_W
  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sec && !ld_wr) |=> ((cnt_q - $past(cnt_q)) == DATA_W'(1)));

  // R2: without tick or load the count holds
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_sec && !ld_wr) |=> $stable(cnt_q));

  // R3: a load write places its data in the count
  a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> (cnt_q == $past(bus_wdata)));

  // R4 / R5: a match event leaves the flag set
  a_r4_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_q);

  // R4: the flag never rises without a match event
  a_r4_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !match_evt) |=> !flag_q);

  // R7: a clear write with no coinciding event drops the flag
  a_r7_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !match_evt) |=> !flag_q);

  // R6: clearing the enable silences the interrupt
  a_r6_enable_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !bus_wdata[0]) |=> !irq);

  // R6: the interrupt never asserts without the enable
  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (enable_q && flag_q));

  // R8: control reads as one
  a_r8_ctrl_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |=> (bus_rdata == DATA_W'(1)));

  // R10: addresses outside both windows read as zero
  a_r10_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hole_rd |=> (bus_rdata == '0));

  // R11: read data holds when no read is requested
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> $stable(bus_rdata));

endmodule

bind sec_alarm_rtc sec_alarm_rtc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_sec (tick_sec),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq      (irq),
  .cnt_q    (cnt_q),
  .flag_q   (flag_q),
  .enable_q (enable_q),
  .match_evt(match_evt)
);

// File: tb/sec_alarm_rtc_bench.sv
module sec_alarm_rtc_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_COUNT = 12'h000;
  localparam logic [11:0] A_MATCH = 12'h004;
  localparam logic [11:0] A_LOAD  = 12'h008;
  localparam logic [11:0] A_CTRL  = 12'h00C;
  localparam logic [11:0] A_EN    = 12'h010;
  localparam logic [11:0] A_RAW   = 12'h014;
  localparam logic [11:0] A_MSK   = 12'h018;
  localparam logic [11:0] A_CLR   = 12'h01C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_sec = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  sec_alarm_rtc u_sec_alarm_rtc (
    .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // All drives happen at falling edges; one posedge lies between.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick();
    tick_sec = 1'b1;
    @(negedge clk);
    tick_sec = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_COUNT, v); chk("R1 count", v, 32'h0);
    rd(A_MATCH, v); chk("R1 match", v, 32'h0);
    rd(A_LOAD, v);  chk("R1 load", v, 32'h0);
    rd(A_EN, v);    chk("R1 enable", v, 32'h0);
    rd(A_RAW, v);   chk("R1 flag", v, 32'h0);
  endtask

  task automatic t_count_load();
    logic [31:0] v;
    wr(A_MATCH, 32'hDEAD_0000);
    wr(A_LOAD, 32'h0000_1000);
    rd(A_LOAD, v);  chk("R3 load readback", v, 32'h0000_1000);
    rd(A_COUNT, v); chk("R3 count loaded", v, 32'h0000_1000);
    for (int i = 0; i < 5; i++) tick();
    rd(A_COUNT, v); chk("R2 five ticks", v, 32'h0000_1005);
    // load and tick in the same cycle: load wins
    tick_sec = 1'b1;
    wr(A_LOAD, 32'h0000_0042);
    tick_sec = 1'b0;
    rd(A_COUNT, v); chk("R3 load beats tick", v, 32'h0000_0042);
    wr(A_LOAD, 32'hFFFF_FFFF);
    tick();
    rd(A_COUNT, v); chk("R2 wrap to zero", v, 32'h0);
    // R11: read returns request-cycle value, holds afterwards
    rd(A_COUNT, v);
    tick();
    chk("R11 rdata held", bus_rdata, 32'h0);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    wr(A_CLR, 32'h0);
    wr(A_LOAD, 32'd100);
    wr(A_MATCH, 32'd102);
    tick();
    rd(A_RAW, v); chk("R4 not yet", v, 32'h0);
    tick();
    rd(A_RAW, v); chk("R4 flag at match", v, 32'h1);
    wr(A_CLR, 32'h0);
    rd(A_RAW, v); chk("R7 clear with zero data", v, 32'h0);
    // count stays equal to match: no new event after clear
    rd(A_RAW, v); chk("R4 no re-fire while equal", v, 32'h0);
    // wrap: match below count
    wr(A_LOAD, 32'hFFFF_FFFE);
    wr(A_MATCH, 32'h1);
    tick(); tick();
    rd(A_RAW, v); chk("R4 before wrap", v, 32'h0);
    tick();
    rd(A_RAW, v); chk("R4 after wrap", v, 32'h1);
    wr(A_CLR, 32'hFFFF_FFFF);
    // immediate fire on match write equal to count (count=1)
    wr(A_MATCH, 32'h1);
    rd(A_RAW, v); chk("R5 match write equal", v, 32'h1);
    wr(A_CLR, 32'h5);
    wr(A_MATCH, 32'd77);
    rd(A_RAW, v); chk("R5 unequal match write", v, 32'h0);
    wr(A_LOAD, 32'd77);
    rd(A_RAW, v); chk("R5 load write equal", v, 32'h1);
    // clear and match event together: event wins
    wr(A_CLR, 32'h0);
    wr(A_MATCH, 32'd78);
    tick_sec = 1'b1;
    wr(A_CLR, 32'h0);
    tick_sec = 1'b0;
    rd(A_RAW, v); chk("R7 event beats clear", v, 32'h1);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    // flag is 1 here
    wr(A_EN, 32'h0);
    chk("R6 irq off when disabled", {31'b0, irq}, 32'h0);
    rd(A_MSK, v); chk("R6 masked status zero", v, 32'h0);
    wr(A_EN, 32'h3);
    chk("R6 irq on", {31'b0, irq}, 32'h1);
    rd(A_EN, v);  chk("R6 enable bit0 only", v, 32'h1);
    rd(A_MSK, v); chk("R6 masked status one", v, 32'h1);
    rd(A_RAW, v); chk("R6 raw status", v, 32'h1);
    wr(A_EN, 32'hFFFF_FFFE);
    chk("R6 bit1 ignored", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h1);
    wr(A_CLR, 32'h0);
    chk("R6 irq follows clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl_id_holes();
    logic [31:0] v;
    logic [7:0] ids [8];
    ids = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R8 control reads one", v, 32'h1);
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i * 4), v);
      chk("R9 id byte", v, {24'h0, ids[i]});
    end
    wr(A_LOAD, 32'h0000_0500);
    wr(A_MATCH, 32'h0000_0600);
    // flag currently 0: try to set it through read-only offsets
    wr(A_COUNT, 32'h1234_5678);
    wr(A_RAW, 32'h1);
    wr(A_MSK, 32'h1);
    wr(12'hFE0, 32'hFF);
    wr(12'h040, 32'hAAAA_AAAA);
    wr(12'h800, 32'h5555_5555);
    rd(A_COUNT, v); chk("R10 count untouched", v, 32'h0000_0500);
    rd(A_RAW, v);   chk("R10 flag untouched", v, 32'h0);
    rd(A_MATCH, v); chk("R10 match untouched", v, 32'h0000_0600);
    rd(A_LOAD, v);  chk("R10 load untouched", v, 32'h0000_0500);
    rd(A_EN, v);    chk("R10 enable untouched", v, 32'h1);
    rd(12'hFE0, v); chk("R10 id untouched", v, 32'h31);
    rd(A_CLR, v);   chk("R10 clear reads zero", v, 32'h0);
    rd(12'h040, v); chk("R10 hole reads zero", v, 32'h0);
    rd(12'h800, v); chk("R10 far hole zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_load();
    t_alarm();
    t_irq();
    t_ctrl_id_holes();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule